// File: doc/BRIEF.md
# Two-Wire Bus Start/Stop Condition Detector

This block watches the clock line and data line of a two-wire serial bus with a fast system clock. It brings each raw line into the clock domain through a two-flop synchroniser. It then passes the line through a glitch filter, which accepts a new level only once that level has been seen for a set number of consecutive samples. The filtered pair goes to a small state machine, which classifies every change into bus events.

The classifier's state is the last filtered line pair. Its four states are `PAIR_LL`, `PAIR_LH`, `PAIR_HL` and `PAIR_HH`, encoded {clock, data}. The named transitions are:
- `PAIR_HH -> PAIR_HL`: start.
- `PAIR_HL -> PAIR_HH`: stop.
- Any move of the clock bit from 0 to 1: clock rise.
- Any move of the clock bit from 1 to 0: clock fall.
- A data-only move while the clock is low: data, with no event.
- A diagonal move, where both lines change in one cycle: clock edge only.

Each filter is a two-state machine. In `FLT_SETTLED` the sample matches the accepted level. In `FLT_CHANGING` a run of differing samples is being counted. The transition `FLT_CHANGING -> FLT_SETTLED` either accepts the new level when the run completes, or drops the run when the sample falls back.

A protocol engine uses the one-cycle strobes to drive its bit counter. It must return to idle on any start or stop, including one seen in the middle of a byte.

Top module: `twb_cond_detect`

## Requirements
- R1: After reset both filtered outputs are 1 and no event strobe is asserted until a filtered line actually changes.
- R2: A raw pulse on either line lasting at most SPIKE_PS/CLK_PERIOD_PS system clocks (10 with defaults) leaves the filtered output unchanged and produces no event.
- R3: A raw level held for at least STABLE_SAMPLES = SPIKE_PS/CLK_PERIOD_PS+1 clocks (11) is accepted, and the filtered output changes on the (STABLE_SAMPLES+2)-th rising clock edge that samples the new raw level (13th with defaults).
- R4: A filtered data fall while the filtered clock stays 1 raises `start_pulse`.
- R5: A filtered data rise while the filtered clock stays 1 raises `stop_pulse`.
- R6: Data changes while the filtered clock is 0 raise neither `start_pulse` nor `stop_pulse`.
- R7: A filtered clock rise raises `scl_rise`, and a filtered clock fall raises `scl_fall`.
- R8: Every strobe lasts exactly one system clock. `start_pulse` and `stop_pulse` are never high together, and neither are `scl_rise` and `scl_fall`. Every strobe follows the filtered-output change that causes it by one clock.
- R9: When both filtered lines change in the same cycle, only the clock edge strobe is raised and no start or stop is reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_raw | input | 1 | Raw bus clock line level |
| sda_raw | input | 1 | Raw bus data line level |
| scl_filt | output | 1 | Filtered bus clock level |
| sda_filt | output | 1 | Filtered bus data level |
| start_pulse | output | 1 | One-cycle start condition strobe |
| stop_pulse | output | 1 | One-cycle stop condition strobe |
| scl_rise | output | 1 | One-cycle filtered clock rising strobe |
| scl_fall | output | 1 | One-cycle filtered clock falling strobe |

## Verification
The assertions assume that the raw lines are driven to defined 0/1 values and that reset is applied before the first event. The start and stop properties also assume that at most one condition can arise from a single filtered transition. The stimulus changes raw levels only on falling system-clock edges and holds every intended level well beyond the filter window. It keeps glitches at or below the rejection width, and it sequences data edges so that each start, stop or data bit arises from one clean filtered transition, except in the deliberate simultaneous-change test.

// File: rtl/twb_pkg.sv
package twb_pkg;

    typedef enum logic {
        FLT_SETTLED  = 1'b0,
        FLT_CHANGING = 1'b1
    } flt_state_t;

    // encoded {clock, data}
    typedef enum logic [1:0] {
        PAIR_LL = 2'b00,
        PAIR_LH = 2'b01,
        PAIR_HL = 2'b10,
        PAIR_HH = 2'b11
    } pair_state_t;

endpackage

// File: rtl/twb_sync.sv
module twb_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic meta_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= 1'b1;
            dout   <= 1'b1;
        end else begin
            meta_q <= din;
            dout   <= meta_q;
        end
    end
endmodule

// File: rtl/twb_glitch_filter.sv
module twb_glitch_filter #(
    parameter int STABLE_SAMPLES = 11
) (
    input  logic clk,
    input  logic rst_n,
    input  logic smp,
    output logic lvl
);
    import twb_pkg::*;

    localparam int CNT_W = (STABLE_SAMPLES > 2) ? $clog2(STABLE_SAMPLES) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(STABLE_SAMPLES - 1);

    flt_state_t       st_q, st_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             lvl_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= FLT_SETTLED;
            cnt_q <= '0;
            lvl   <= 1'b1;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
            lvl   <= lvl_d;
        end
    end

    // next state and outputs
    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        lvl_d = lvl;
        unique case (st_q)
            FLT_SETTLED: begin
                if (smp != lvl) begin
                    st_d  = FLT_CHANGING;
                    cnt_d = CNT_W'(1);
                end
            end
            FLT_CHANGING: begin
                if (smp == lvl) begin
                    st_d  = FLT_SETTLED;
                    cnt_d = '0;
                end else if (cnt_q == LAST) begin
                    st_d  = FLT_SETTLED;
                    cnt_d = '0;
                    lvl_d = smp;
                end else begin
                    cnt_d = cnt_q + CNT_W'(1);
                end
            end
        endcase
    end

    AST_FLT_NEEDS_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl != $past(lvl)) |-> ($past(smp) == lvl)); // R3
endmodule

// File: rtl/twb_edge_classifier.sv
module twb_edge_classifier (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_f,
    input  logic sda_f,
    output logic start_pulse,
    output logic stop_pulse,
    output logic scl_rise,
    output logic scl_fall
);
    import twb_pkg::*;

    pair_state_t cur_q, nxt;
    logic start_d, stop_d, rise_d, fall_d;

    assign nxt = pair_state_t'({scl_f, sda_f});

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q       <= PAIR_HH;
            start_pulse <= 1'b0;
            stop_pulse  <= 1'b0;
            scl_rise    <= 1'b0;
            scl_fall    <= 1'b0;
        end else begin
            cur_q       <= nxt;
            start_pulse <= start_d;
            stop_pulse  <= stop_d;
            scl_rise    <= rise_d;
            scl_fall    <= fall_d;
        end
    end

    // transition classification
    always_comb begin
        start_d = 1'b0;
        stop_d  = 1'b0;
        rise_d  = 1'b0;
        fall_d  = 1'b0;
        unique case (cur_q)
            PAIR_HH: begin
                start_d = (nxt == PAIR_HL);
                fall_d  = !nxt[1];
            end
            PAIR_HL: begin
                stop_d  = (nxt == PAIR_HH);
                fall_d  = !nxt[1];
            end
            PAIR_LH,
            PAIR_LL: begin
                rise_d  = nxt[1];
            end
        endcase
    end

    AST_NO_START_WITH_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        !(start_pulse && stop_pulse)); // R8
    AST_NO_RISE_WITH_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        !(scl_rise && scl_fall)); // R8
    AST_START_NEEDS_CLK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        start_pulse |-> ($past(scl_f) && !$past(sda_f))); // R4
    AST_STOP_NEEDS_CLK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        stop_pulse |-> ($past(scl_f) && $past(sda_f))); // R5
    AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        start_pulse |=> !start_pulse); // R8
endmodule

// File: rtl/twb_cond_detect.sv
module twb_cond_detect #(
    parameter int CLK_PERIOD_PS = 5000,
    parameter int SPIKE_PS      = 50000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_raw,
    input  logic sda_raw,
    output logic scl_filt,
    output logic sda_filt,
    output logic start_pulse,
    output logic stop_pulse,
    output logic scl_rise,
    output logic scl_fall
);
    localparam int STABLE_SAMPLES = SPIKE_PS / CLK_PERIOD_PS + 1;
    localparam int LINES = 2;

    logic [LINES-1:0] raw_v, sync_v, filt_v;

    // bit 1 = clock line, bit 0 = data line
    assign raw_v = {scl_raw, sda_raw};

    for (genvar g = 0; g < LINES; g++) begin : g_line
        twb_sync u_sync (
            .clk  (clk),
            .rst_n(rst_n),
            .din  (raw_v[g]),
            .dout (sync_v[g])
        );
        twb_glitch_filter #(.STABLE_SAMPLES(STABLE_SAMPLES)) u_filt (
            .clk  (clk),
            .rst_n(rst_n),
            .smp  (sync_v[g]),
            .lvl  (filt_v[g])
        );
    end

    assign scl_filt = filt_v[1];
    assign sda_filt = filt_v[0];

    twb_edge_classifier u_cls (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_f      (filt_v[1]),
        .sda_f      (filt_v[0]),
        .start_pulse(start_pulse),
        .stop_pulse (stop_pulse),
        .scl_rise   (scl_rise),
        .scl_fall   (scl_fall)
    );
endmodule

// File: tb/twb_cond_detect_tb.sv
`timescale 1ns/1ps
module twb_cond_detect_tb_top;
    localparam int N = 11;   // accept run length with default parameters
    localparam int W = N + 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_raw = 1'b1, sda_raw = 1'b1;
    logic scl_filt, sda_filt, start_pulse, stop_pulse, scl_rise, scl_fall;

    int checks = 0, failures = 0, cycles = 0;
    int n_start = 0, n_stop = 0, n_rise = 0, n_fall = 0;
    string phase_req = "R1";

    // reference model state
    int  hq_scl[$], hq_sda[$];
    bit  m_scl = 1, m_sda = 1, p_scl = 1, p_sda = 1;
    bit  e_start = 0, e_stop = 0, e_rise = 0, e_fall = 0;

    always #2.5 clk = ~clk;

    twb_cond_detect dut_i (
        .clk(clk), .rst_n(rst_n), .scl_raw(scl_raw), .sda_raw(sda_raw),
        .scl_filt(scl_filt), .sda_filt(sda_filt), .start_pulse(start_pulse),
        .stop_pulse(stop_pulse), .scl_rise(scl_rise), .scl_fall(scl_fall)
    );

    task automatic check(input string req, input int act, input int exp, input string what);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic bit run_flip(ref int q[$], input bit cur);
        // samples r[t-2] .. r[t-1-N] are queue indices 2..N+1
        for (int i = 2; i <= N + 1; i++)
            if (q[i] == int'(cur)) return 1'b0;
        return 1'b1;
    endfunction

    initial begin
        for (int i = 0; i < W; i++) begin
            hq_scl.push_back(1);
            hq_sda.push_back(1);
        end
    end

    // behavioural reference, advanced on every clock
    always @(posedge clk) begin
        if (rst_n) begin
            bit n_scl, n_sda;
            hq_scl.push_front(int'(scl_raw)); void'(hq_scl.pop_back());
            hq_sda.push_front(int'(sda_raw)); void'(hq_sda.pop_back());
            // events describe the change p -> m seen one clock earlier
            e_rise  = !p_scl && m_scl;
            e_fall  = p_scl && !m_scl;
            e_start = p_scl && m_scl && p_sda && !m_sda;
            e_stop  = p_scl && m_scl && !p_sda && m_sda;
            n_scl = run_flip(hq_scl, m_scl) ? !m_scl : m_scl;
            n_sda = run_flip(hq_sda, m_sda) ? !m_sda : m_sda;
            p_scl = m_scl; p_sda = m_sda;
            m_scl = n_scl; m_sda = n_sda;
        end
    end

    // per-clock comparison and event counting
    always @(negedge clk) begin
        cycles++;
        if (rst_n) begin
            check(phase_req, scl_filt, m_scl, "model scl_filt");
            check(phase_req, sda_filt, m_sda, "model sda_filt");
            check({phase_req, "/R8"}, start_pulse, e_start, "model start_pulse");
            check({phase_req, "/R8"}, stop_pulse, e_stop, "model stop_pulse");
            check({phase_req, "/R7"}, scl_rise, e_rise, "model scl_rise");
            check({phase_req, "/R7"}, scl_fall, e_fall, "model scl_fall");
            n_start += start_pulse; n_stop += stop_pulse;
            n_rise += scl_rise; n_fall += scl_fall;
        end
        if (cycles > 20000) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected<=20000", cycles);
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic wait_clk(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic clear_counts();
        n_start = 0; n_stop = 0; n_rise = 0; n_fall = 0;
    endtask

    initial begin
        wait_clk(3);
        // R1: reset state
        check("R1", scl_filt, 1, "scl_filt in reset");
        check("R1", sda_filt, 1, "sda_filt in reset");
        rst_n = 1'b1;
        wait_clk(20);
        check("R1", n_start + n_stop + n_rise + n_fall, 0, "events after reset");

        // R2: glitches at the rejection limit
        phase_req = "R2"; clear_counts();
        sda_raw = 1'b0; wait_clk(N - 1); sda_raw = 1'b1; wait_clk(20);
        scl_raw = 1'b0; wait_clk(N - 1); scl_raw = 1'b1; wait_clk(20);
        sda_raw = 1'b0; wait_clk(3);     sda_raw = 1'b1; wait_clk(20);
        check("R2", sda_filt, 1, "sda_filt after glitch");
        check("R2", scl_filt, 1, "scl_filt after glitch");
        check("R2", n_start + n_stop + n_rise + n_fall, 0, "events from glitches");

        // R3 + R4: start, with exact acceptance latency
        phase_req = "R4"; clear_counts();
        sda_raw = 1'b0;
        @(posedge clk);        // first edge sampling the new level
        wait_clk(N + 1);       // N+1 edges sampled so far
        check("R3", sda_filt, 1, "sda_filt before latency");
        wait_clk(1);
        check("R3", sda_filt, 0, "sda_filt at latency");
        wait_clk(3);
        check("R4", n_start, 1, "start count");
        check("R4", n_stop, 0, "stop count in start");

        // R7 + R6: clock low, data toggles
        phase_req = "R6"; clear_counts();
        scl_raw = 1'b0; wait_clk(20);
        sda_raw = 1'b1; wait_clk(20);
        sda_raw = 1'b0; wait_clk(20);
        sda_raw = 1'b1; wait_clk(20);
        sda_raw = 1'b0; wait_clk(20);
        check("R6", n_start + n_stop, 0, "start/stop during data");
        check("R7", n_fall, 1, "scl_fall count");

        // R7 + R5: clock high then stop
        phase_req = "R5"; clear_counts();
        scl_raw = 1'b1; wait_clk(20);
        check("R7", n_rise, 1, "scl_rise count");
        sda_raw = 1'b1; wait_clk(20);
        check("R5", n_stop, 1, "stop count");
        check("R5", n_start, 0, "start count in stop");

        // R9: both lines change together
        phase_req = "R9"; clear_counts();
        scl_raw = 1'b0; sda_raw = 1'b0; wait_clk(20);
        scl_raw = 1'b1; sda_raw = 1'b1; wait_clk(20);
        check("R9", n_start + n_stop, 0, "start/stop on diagonal change");
        check("R9", n_fall, 1, "scl_fall on diagonal change");
        check("R9", n_rise, 1, "scl_rise on diagonal change");

        // R8: repeated start/stop cycles
        phase_req = "R8"; clear_counts();
        for (int k = 0; k < 3; k++) begin
            sda_raw = 1'b0; wait_clk(15);
            sda_raw = 1'b1; wait_clk(15);
        end
        check("R8", n_start, 3, "start strobes over three cycles");
        check("R8", n_stop, 3, "stop strobes over three cycles");

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule